// File: doc/BRIEF.md
# Link Speed Fallback Sequencer

This block brings a PCIe link up in two steps. Some link partners do not train when the first attempt runs at a higher rate, so the sequencer first trains at the lowest rate and then moves the link to the rate it is configured for. When a start pulse arrives, it opens the write protection on the capability registers. It reads the link-capability word and keeps its supported-speed field. It then writes the same word back with that field set to the lowest-rate code, enables link training and waits for the link to come up.

Once the link is up, the sequencer reads the capability word again. If the speed field no longer matches the saved value, it writes the saved value back. It then does a read-modify-write on the width/speed control register to set its directed-speed-change bit, and waits for the link to come up a second time. Every wait on the link is bounded by a cycle timeout. A timeout ends the sequence with an error and skips all later steps. Write protection is closed again on both outcomes.

All register traffic goes through a single valid/ready request port, with one request outstanding at a time. The requester raises `cfg_valid` and holds `cfg_write`, `cfg_sel` and `cfg_wdata` steady until it sees `cfg_ready` high at a clock edge. The responder may hold `cfg_ready` low for any number of cycles, and that back-pressure only stalls the sequence. For a read, `cfg_rdata` must be valid in the same cycle that `cfg_ready` is high.

Top module: `link_speed_fallback`

## Requirements
- R1: A `start` pulse in the idle state begins a sequence. In the next cycle `ro_unlock` rises and `done` and `err` both read 0. A `start` pulse while a sequence is running is ignored and changes neither the register traffic nor the result.
- R2: The first access reads the link-capability word (`cfg_sel`=0) and saves its speed field, bits [3:0]. The second access writes the same word back with bits [3:0] set to the lowest-rate code 1 and every other bit unchanged.
- R3: After the lowest-rate write completes, `train_en` rises and stays high until reset.
- R4: The first link wait ends with a timeout when `link_up` stays low. `err` then rises exactly LINK_TIMEOUT+2 cycles after `train_en` rises, and no further register access follows the first two.
- R5: After the first link-up, the sequencer re-reads the capability word. If its bits [3:0] differ from the saved value, it writes the word back with the saved value in bits [3:0]. It then reads the width/speed control word (`cfg_sel`=1) and writes it back with bit SPD_CHG_BIT (default 17) set and every other bit unchanged.
- R6: If the re-read speed field equals the saved value, the sequence ends with `done` after three accesses and never touches the control register.
- R7: After the speed-change write, the sequencer waits for `link_up` again under the same timeout. A timeout there ends the sequence with `err`.
- R8: `ro_unlock` stays high from start until the result is flagged and is low whenever `done` or `err` is high. Writes to the capability word happen only while it is high.
- R9: `done` and `err` are never high together. Each stays high until the next accepted `start`.
- R10: While `cfg_valid` is high and `cfg_ready` is low, `cfg_valid`, `cfg_write`, `cfg_sel` and `cfg_wdata` hold their values.
- R11: During and right after reset, `done`, `err`, `train_en`, `ro_unlock` and `cfg_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run the sequence |
| done | output | 1 | Sequence ended with the link up; held until the next start |
| err | output | 1 | Sequence ended on a link timeout; held until the next start |
| train_en | output | 1 | Link-training enable |
| link_up | input | 1 | Link-up indication from the link layer |
| ro_unlock | output | 1 | Opens writes to read-only capability registers |
| cfg_valid | output | 1 | Register request valid |
| cfg_ready | input | 1 | Register request accepted; read data valid |
| cfg_write | output | 1 | 1 = write, 0 = read |
| cfg_sel | output | 1 | 0 = link-capability word, 1 = width/speed control word |
| cfg_wdata | output | DW | Write data |
| cfg_rdata | input | DW | Read data, valid while cfg_ready is high |

## Verification
The bench targets these corner cases:

- **Saved field already the lowest code.** A design that restores anyway would issue six accesses instead of three and would set the speed-change bit when it should not.
- **Timeout in the first wait.** The bench measures the cycle of `err` and counts the accesses. A sequencer that ran on into the restore, or that counted the window wrong, would show an extra access or a shifted `err` edge.
- **Timeout in the second wait.** This confirms that an error after the restore still closes write protection.
- **Read-modify-write bits.** The tests use non-zero upper bits in both words, so a write that clobbers neighbouring fields shows up in the final register contents.
- **Result after the run.** The bench holds off for a while and checks the result is still there. It then restarts, and also pulses `start` mid-run, so a result that decays, or a restart taken mid-run, changes the observed flags or the access count.

// File: rtl/lsf_pkg.sv
package lsf_pkg;

  // register select on the request port
  localparam logic SEL_LINKCAP = 1'b0;
  localparam logic SEL_SPDCTL  = 1'b1;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_CAP,
    ST_WR_LOW,
    ST_TRAIN,
    ST_RD_CAP2,
    ST_WR_ORIG,
    ST_RD_CTL,
    ST_WR_CTL,
    ST_RETRAIN,
    ST_END
  } seq_st_e;

  function automatic logic st_is_access(seq_st_e s);
    return (s == ST_RD_CAP) || (s == ST_WR_LOW) || (s == ST_RD_CAP2) ||
           (s == ST_WR_ORIG) || (s == ST_RD_CTL) || (s == ST_WR_CTL);
  endfunction

  function automatic logic st_is_write(seq_st_e s);
    return (s == ST_WR_LOW) || (s == ST_WR_ORIG) || (s == ST_WR_CTL);
  endfunction

  function automatic logic st_is_wait(seq_st_e s);
    return (s == ST_TRAIN) || (s == ST_RETRAIN);
  endfunction

endpackage

// File: rtl/lsf_cfg_port.sv
module lsf_cfg_port #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_write,
  input  logic          go_sel,
  input  logic [DW-1:0] go_wdata,
  output logic          op_done,
  output logic [DW-1:0] op_rdata,
  output logic          cfg_valid,
  input  logic          cfg_ready,
  output logic          cfg_write,
  output logic          cfg_sel,
  output logic [DW-1:0] cfg_wdata,
  input  logic [DW-1:0] cfg_rdata
);

  logic          valid_q;
  logic          write_q;
  logic          sel_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      write_q <= 1'b0;
      sel_q   <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (valid_q) begin
        if (cfg_ready) begin
          valid_q <= 1'b0;
          done_q  <= 1'b1;
          if (!write_q) rdata_q <= cfg_rdata;
        end
      end else if (go) begin
        valid_q <= 1'b1;
        write_q <= go_write;
        sel_q   <= go_sel;
        wdata_q <= go_wdata;
      end
    end
  end

  assign cfg_valid = valid_q;
  assign cfg_write = write_q;
  assign cfg_sel   = sel_q;
  assign cfg_wdata = wdata_q;
  assign op_done   = done_q;
  assign op_rdata  = rdata_q;

endmodule

// File: rtl/lsf_link_timer.sv
module lsf_link_timer #(
  parameter int unsigned TIMEOUT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);

  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic [CW-1:0] cnt_q;

  assign expired = (cnt_q == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
    end else if (!expired) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/lsf_seq.sv
module lsf_seq
  import lsf_pkg::*;
#(
  parameter int unsigned     DW          = 32,
  parameter int unsigned     SPD_W       = 4,
  parameter logic [SPD_W-1:0] LOW_CODE   = 1,
  parameter int unsigned     SPD_CHG_BIT = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          link_up,
  input  logic          tmr_expired,
  output logic          tmr_run,
  output logic          go,
  output logic          go_write,
  output logic          go_sel,
  output logic [DW-1:0] go_wdata,
  input  logic          op_done,
  input  logic [DW-1:0] op_rdata,
  output logic          done,
  output logic          err,
  output logic          train_en,
  output logic          ro_unlock
);

  localparam logic [DW-1:0] FIELD_MASK = DW'((64'd1 << SPD_W) - 64'd1);
  localparam logic [DW-1:0] CHG_MASK   = DW'(64'd1 << SPD_CHG_BIT);
  localparam int unsigned   PAD_W      = DW - SPD_W;

  seq_st_e          st_q;
  logic             issued_q;
  logic [SPD_W-1:0] saved_q;
  logic             fail_q;
  logic             done_q;
  logic             err_q;
  logic             train_q;
  logic             unlock_q;

  logic [SPD_W-1:0] rd_field;
  logic [DW-1:0]    rd_kept;

  assign rd_field = op_rdata[SPD_W-1:0];
  assign rd_kept  = op_rdata & ~FIELD_MASK;

  assign go       = st_is_access(st_q) && !issued_q;
  assign go_write = st_is_write(st_q);
  assign go_sel   = ((st_q == ST_RD_CTL) || (st_q == ST_WR_CTL)) ? SEL_SPDCTL : SEL_LINKCAP;
  assign tmr_run  = st_is_wait(st_q);

  always_comb begin
    unique case (st_q)
      ST_WR_LOW:  go_wdata = rd_kept | {{PAD_W{1'b0}}, LOW_CODE};
      ST_WR_ORIG: go_wdata = rd_kept | {{PAD_W{1'b0}}, saved_q};
      ST_WR_CTL:  go_wdata = op_rdata | CHG_MASK;
      default:    go_wdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      issued_q <= 1'b0;
      saved_q  <= '0;
      fail_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      train_q  <= 1'b0;
      unlock_q <= 1'b0;
    end else begin
      if (go)      issued_q <= 1'b1;
      if (op_done) issued_q <= 1'b0;

      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q     <= ST_RD_CAP;
            unlock_q <= 1'b1;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            fail_q   <= 1'b0;
          end
        end
        ST_RD_CAP: begin
          if (op_done) begin
            saved_q <= rd_field;
            st_q    <= ST_WR_LOW;
          end
        end
        ST_WR_LOW: begin
          if (op_done) begin
            train_q <= 1'b1;
            st_q    <= ST_TRAIN;
          end
        end
        ST_TRAIN: begin
          if (link_up) begin
            st_q <= ST_RD_CAP2;
          end else if (tmr_expired) begin
            fail_q <= 1'b1;
            st_q   <= ST_END;
          end
        end
        ST_RD_CAP2: begin
          if (op_done) st_q <= (rd_field != saved_q) ? ST_WR_ORIG : ST_END;
        end
        ST_WR_ORIG: begin
          if (op_done) st_q <= ST_RD_CTL;
        end
        ST_RD_CTL: begin
          if (op_done) st_q <= ST_WR_CTL;
        end
        ST_WR_CTL: begin
          if (op_done) st_q <= ST_RETRAIN;
        end
        ST_RETRAIN: begin
          if (link_up) begin
            st_q <= ST_END;
          end else if (tmr_expired) begin
            fail_q <= 1'b1;
            st_q   <= ST_END;
          end
        end
        ST_END: begin
          unlock_q <= 1'b0;
          done_q   <= !fail_q;
          err_q    <= fail_q;
          fail_q   <= 1'b0;
          st_q     <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done      = done_q;
  assign err       = err_q;
  assign train_en  = train_q;
  assign ro_unlock = unlock_q;

endmodule

// File: rtl/link_speed_fallback.sv
module link_speed_fallback #(
  parameter int unsigned      DW           = 32,
  parameter int unsigned      SPD_W        = 4,
  parameter logic [SPD_W-1:0] LOW_CODE     = 1,
  parameter int unsigned      SPD_CHG_BIT  = 17,
  parameter int unsigned      LINK_TIMEOUT = 100000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          done,
  output logic          err,
  output logic          train_en,
  input  logic          link_up,
  output logic          ro_unlock,
  output logic          cfg_valid,
  input  logic          cfg_ready,
  output logic          cfg_write,
  output logic          cfg_sel,
  output logic [DW-1:0] cfg_wdata,
  input  logic [DW-1:0] cfg_rdata
);

  logic          tmr_run;
  logic          tmr_expired;
  logic          go;
  logic          go_write;
  logic          go_sel;
  logic [DW-1:0] go_wdata;
  logic          op_done;
  logic [DW-1:0] op_rdata;

  lsf_seq #(
    .DW          (DW),
    .SPD_W       (SPD_W),
    .LOW_CODE    (LOW_CODE),
    .SPD_CHG_BIT (SPD_CHG_BIT)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .link_up     (link_up),
    .tmr_expired (tmr_expired),
    .tmr_run     (tmr_run),
    .go          (go),
    .go_write    (go_write),
    .go_sel      (go_sel),
    .go_wdata    (go_wdata),
    .op_done     (op_done),
    .op_rdata    (op_rdata),
    .done        (done),
    .err         (err),
    .train_en    (train_en),
    .ro_unlock   (ro_unlock)
  );

  lsf_link_timer #(
    .TIMEOUT (LINK_TIMEOUT)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (tmr_run),
    .expired (tmr_expired)
  );

  lsf_cfg_port #(
    .DW (DW)
  ) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .go_write  (go_write),
    .go_sel    (go_sel),
    .go_wdata  (go_wdata),
    .op_done   (op_done),
    .op_rdata  (op_rdata),
    .cfg_valid (cfg_valid),
    .cfg_ready (cfg_ready),
    .cfg_write (cfg_write),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata)
  );

endmodule

// File: rtl/lsf_chk.sv
module lsf_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic          err,
  input logic          train_en,
  input logic          ro_unlock,
  input logic          cfg_valid,
  input logic          cfg_ready,
  input logic          cfg_write,
  input logic          cfg_sel,
  input logic [DW-1:0] cfg_wdata
);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_write) &&
                                $stable(cfg_sel) && $stable(cfg_wdata));

  // R9
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err && !start |=> err);

  // R8
  cap_wr_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_write && (cfg_sel == 1'b0) |-> ro_unlock);

  // R8
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !ro_unlock);

  // R3
  train_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    train_en |=> train_en);

  // R4
  quiet_after_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !cfg_valid);

endmodule

bind link_speed_fallback lsf_chk #(.DW(DW)) u_lsf_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .done      (done),
  .err       (err),
  .train_en  (train_en),
  .ro_unlock (ro_unlock),
  .cfg_valid (cfg_valid),
  .cfg_ready (cfg_ready),
  .cfg_write (cfg_write),
  .cfg_sel   (cfg_sel),
  .cfg_wdata (cfg_wdata)
);

// File: tb/link_speed_fallback_bench.sv
module link_speed_fallback_bench;

  localparam int unsigned DW      = 32;
  localparam int unsigned TMO     = 40;
  localparam int unsigned CHG_BIT = 17;
  localparam logic [DW-1:0] CHG_MASK = 32'h1 << CHG_BIT;
  localparam logic [DW-1:0] CTL_INIT = 32'h0000_0C0A;
  localparam logic [DW-1:0] CAP_BASE = 32'h1234_5670;

  typedef struct packed {
    logic [3:0] orig;
    logic [7:0] d1;      // cycles to link-up after low write, 0 = never
    logic [7:0] d2;      // cycles to link-up after speed change, 0 = never
    logic [2:0] lat;     // ready wait states
    logic       exp_err;
    logic       exp_chg;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{orig: 4'd3, d1: 8'd5,  d2: 8'd4,  lat: 3'd0, exp_err: 1'b0, exp_chg: 1'b1},
    '{orig: 4'd1, d1: 8'd3,  d2: 8'd0,  lat: 3'd2, exp_err: 1'b0, exp_chg: 1'b0},
    '{orig: 4'd2, d1: 8'd0,  d2: 8'd0,  lat: 3'd1, exp_err: 1'b1, exp_chg: 1'b0},
    '{orig: 4'd4, d1: 8'd2,  d2: 8'd0,  lat: 3'd3, exp_err: 1'b1, exp_chg: 1'b1},
    '{orig: 4'd5, d1: 8'd1,  d2: 8'd1,  lat: 3'd0, exp_err: 1'b0, exp_chg: 1'b1},
    '{orig: 4'd0, d1: 8'd12, d2: 8'd20, lat: 3'd1, exp_err: 1'b0, exp_chg: 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          done, err, train_en, ro_unlock;
  logic          link_up = 1'b0;
  logic          cfg_valid, cfg_write, cfg_sel;
  logic          cfg_ready = 1'b0;
  logic [DW-1:0] cfg_wdata;
  logic [DW-1:0] cfg_rdata = '0;

  int checks = 0;
  int errors = 0;

  // bench-side register and link model
  logic [DW-1:0] cap_reg = '0;
  logic [DW-1:0] ctl_reg = '0;
  int d1 = 0, d2 = 0, lat = 0;
  int lk_cnt = 0, lat_cnt = 0;
  int acc_cnt = 0, chg_cnt = 0, prot_viol = 0, stab_viol = 0;
  logic          pend = 1'b0;
  logic          p_write, p_sel;
  logic [DW-1:0] p_wdata;

  always #4 clk = ~clk;

  link_speed_fallback #(
    .DW           (DW),
    .SPD_CHG_BIT  (CHG_BIT),
    .LINK_TIMEOUT (TMO)
  ) u_link_speed_fallback (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .err       (err),
    .train_en  (train_en),
    .link_up   (link_up),
    .ro_unlock (ro_unlock),
    .cfg_valid (cfg_valid),
    .cfg_ready (cfg_ready),
    .cfg_write (cfg_write),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // responder and link model, driven away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (lk_cnt > 0) begin
        lk_cnt--;
        if (lk_cnt == 0) link_up = 1'b1;
      end
      if (cfg_ready) begin
        cfg_ready = 1'b0;
        pend = 1'b0;
      end else if (cfg_valid && rst_n) begin
        if (!pend) begin
          pend = 1'b1;
          p_write = cfg_write;
          p_sel = cfg_sel;
          p_wdata = cfg_wdata;
        end else if (p_write !== cfg_write || p_sel !== cfg_sel || p_wdata !== cfg_wdata) begin
          stab_viol++;
        end
        if (lat_cnt < lat) begin
          lat_cnt++;
        end else begin
          lat_cnt = 0;
          cfg_ready = 1'b1;
          acc_cnt++;
          if (!cfg_write) begin
            cfg_rdata = cfg_sel ? ctl_reg : cap_reg;
          end else if (!cfg_sel) begin
            if (!ro_unlock) prot_viol++;
            else cap_reg = cfg_wdata;
            if (cfg_wdata[3:0] == 4'd1 && d1 > 0 && acc_cnt == 2) lk_cnt = d1;
          end else begin
            ctl_reg = cfg_wdata;
            if (cfg_wdata[CHG_BIT]) begin
              chg_cnt++;
              link_up = 1'b0;
              lk_cnt = d2;
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic setup(input logic [3:0] orig, input int a, input int b, input int l);
    cap_reg = CAP_BASE | {28'h0, orig};
    ctl_reg = CTL_INIT;
    d1 = a; d2 = b; lat = l;
    lk_cnt = 0; lat_cnt = 0; acc_cnt = 0; chg_cnt = 0; prot_viol = 0;
    link_up = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_result();
    int n = 0;
    while (!(done || err) && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    // R11: reset state
    repeat (2) @(negedge clk);
    check("R11 done", {31'h0, done}, 32'h0);
    check("R11 err", {31'h0, err}, 32'h0);
    check("R11 train_en", {31'h0, train_en}, 32'h0);
    check("R11 ro_unlock", {31'h0, ro_unlock}, 32'h0);
    check("R11 cfg_valid", {31'h0, cfg_valid}, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [3:0] exp_field;
      int exp_acc;
      v = VECS[i];
      do_reset();
      setup(v.orig, int'(v.d1), int'(v.d2), int'(v.lat));
      pulse_start();
      wait_result();
      exp_field = (v.exp_err && !v.exp_chg) ? 4'd1 : v.orig;
      exp_acc   = v.exp_chg ? 6 : (v.exp_err ? 2 : 3);
      check("R9 done", {31'h0, done}, {31'h0, !v.exp_err});
      check(v.exp_chg ? "R7 err" : "R4 err", {31'h0, err}, {31'h0, v.exp_err});
      check("R5 cap speed field", {28'h0, cap_reg[3:0]}, {28'h0, exp_field});
      check("R2 cap upper bits kept", cap_reg & 32'hFFFF_FFF0, CAP_BASE);
      check("R5 ctl word", ctl_reg, v.exp_chg ? (CTL_INIT | CHG_MASK) : CTL_INIT);
      check(v.exp_chg ? "R5 access count" : "R6 access count", acc_cnt, exp_acc);
      check("R8 relocked", {31'h0, ro_unlock}, 32'h0);
      check("R8 protected writes", prot_viol, 0);
      check("R3 train_en held", {31'h0, train_en}, 32'h1);
    end
    check("R10 request fields stable", stab_viol, 0);

    // R4: exact timeout cycle and no traffic afterwards
    begin
      int n = 0;
      do_reset();
      setup(4'd3, 0, 0, 0);
      pulse_start();
      while (!train_en && n < 200) begin @(negedge clk); n++; end
      n = 0;
      while (!err && n < 500) begin @(negedge clk); n++; end
      check("R4 timeout cycles", n, TMO + 2);
      repeat (10) @(negedge clk);
      check("R4 accesses after timeout", acc_cnt, 2);
    end

    // R9 hold, R1 restart clears result, R1 start during run ignored
    do_reset();
    setup(4'd2, 4, 3, 1);
    pulse_start();
    wait_result();
    repeat (30) @(negedge clk);
    check("R9 done held", {31'h0, done}, 32'h1);
    check("R9 err stays low", {31'h0, err}, 32'h0);
    cap_reg = CAP_BASE | 32'h2;
    ctl_reg = CTL_INIT;
    lk_cnt = 0; acc_cnt = 0; chg_cnt = 0;
    link_up = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1 done cleared", {31'h0, done}, 32'h0);
    check("R1 unlock raised", {31'h0, ro_unlock}, 32'h1);
    repeat (12) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_result();
    repeat (10) @(negedge clk);
    check("R1 mid-run start ignored, accesses", acc_cnt, 6);
    check("R1 mid-run start ignored, result", {30'h0, done, err}, 32'h2);
    check("R5 single speed change", chg_cnt, 1);

    summary();
  end

endmodule